// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block turns an asynchronous serial line back into parallel characters. It runs on the system clock and advances its bit timing only on a clock-enable pulse that arrives sixteen times per bit period. That pulse may come from a divider of its own, separate from the one that drives the transmit side. A two-flop synchroniser brings the line in. A falling edge starts a frame, but the receiver accepts the frame only if the line is still low at the middle of the start bit. A glitch shorter than that is dropped, and the receiver goes back to waiting.

The frame format comes from static configuration inputs: five to eight data bits, and an optional parity bit that is checked as even or odd. Only the first stop bit is examined, so any stop-bit count the transmitter uses is accepted. Start, parity and stop bits are removed, and the data bits are stored right-aligned in a holding register with a ready flag. Parity, framing, overrun and line-break conditions are kept as sticky flags until a status-read strobe clears them. A one-cycle pulse tells an interrupt controller that a completed character raised one of them.

Top module: `serial_rx_engine`

## Requirements
- R1: Data bits arrive least significant first. They are stored right-aligned in `rx_data_o`, with the unused upper bits zero. `cfg_len_i` selects the character length: 0 for 5 bits, 1 for 6, 2 for 7, 3 for 8. `rx_ready_o` is set in the same cycle the character is stored.
- R2: The line passes through two flops first. A start is detected on the first enable pulse that sees the line low. The start is validated 8 enable pulses later, and every later bit is sampled 16 enable pulses after the sample before it.
- R3: If the line is high at the validation sample, the start is false. The receiver returns to idle and stores no character, sets no flag and raises no pulse.
- R4: When `cfg_par_en_i` is 1, a parity bit follows the data bits. `cfg_par_even_i` = 1 expects an even count of ones over data and parity, and 0 expects an odd count. A mismatch sets `err_parity_o`.
- R5: A low first stop-bit sample sets `err_frame_o`, unless the frame is a break. Only one stop bit is sampled, so a new start bit may follow a single stop bit at once.
- R6: If every sample of a frame is low (start, data, parity if enabled, and stop), `err_break_o` is set and the character 0x00 is stored. Framing and parity flags are not set for that frame. No further character is assembled until the line has returned high.
- R7: A character that completes while `rx_ready_o` is set (with no data read in that cycle) sets `err_overrun_o`, and the new character replaces the old one.
- R8: The error flags stay set until `stat_rd_i` is pulsed. A flag being set in the same cycle as the strobe wins over the clear.
- R9: `data_rd_i` clears `rx_ready_o`. A character being stored in the same cycle wins over the clear.
- R10: `rx_irq_o` pulses for one cycle, in the cycle the flags update, when a completed character raises any of the four error conditions. It stays low for clean characters.
- R11: After reset, all outputs are zero and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16_i | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| cfg_len_i | input | 2 | Character length code (5 to 8 bits) |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_even_i | input | 1 | 1 even parity, 0 odd parity |
| data_rd_i | input | 1 | Holding register read strobe |
| stat_rd_i | input | 1 | Status read strobe, clears error flags |
| rx_data_o | output | 8 | Received character, right-aligned |
| rx_ready_o | output | 1 | Character waiting |
| err_parity_o | output | 1 | Sticky parity error |
| err_frame_o | output | 1 | Sticky framing error |
| err_overrun_o | output | 1 | Sticky overrun |
| err_break_o | output | 1 | Sticky line break |
| rx_irq_o | output | 1 | One-cycle receive-status pulse |

## Verification
Some rules are checked by assertions on every cycle. These are the false-start return to idle, the sampling window kept open until mid-start, set-over-clear ordering for the ready flag and the sticky flags, overrun on a load into a full register, and the status pulse only ever appearing with a flag raised. Other behaviour only shows up across whole frames, so the bench scenarios cover it. That covers the correct data value for each length and parity mode, parity and framing detection, break handling with its single zero load and wait for the line to rise, back-to-back frames with one stop bit, and the overwrite on overrun.

// File: rtl/rxcore_pkg.sv
package rxcore_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_e;

  typedef struct packed {
    logic parity;
    logic frame;
    logic brk;
  } rx_err_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import rxcore_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int MAX_BITS = 8,
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                rxd_i,
  input  logic [LEN_W-1:0]    cfg_len_i,
  input  logic                par_en_i,
  input  logic                par_even_i,
  output logic                done_o,
  output logic [MAX_BITS-1:0] data_o,
  output rx_err_t             err_o
);
  localparam int CNT_W  = $clog2(OSR);
  localparam int BIDX_W = $clog2(MAX_BITS);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
  localparam logic [LEN_W-1:0] SPAN = LEN_W'(MAX_BITS - MIN_BITS);

  rx_state_e           state_q, state_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [BIDX_W-1:0]   bidx_q, bidx_n;
  logic [MAX_BITS-1:0] shr_q, shr_n;
  logic                par_q, par_n;
  logic                zero_q, zero_n;
  logic                samp;
  logic [BIDX_W-1:0]   last_bit;
  logic                brk;

  assign samp     = tick_i && (cnt_q == LAST);
  assign last_bit = BIDX_W'(MIN_BITS - 1) + BIDX_W'(cfg_len_i);
  assign brk      = zero_q && !rxd_i;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    bidx_n  = bidx_q;
    shr_n   = shr_q;
    par_n   = par_q;
    zero_n  = zero_q;
    done_o  = 1'b0;
    err_o   = '0;
    case (state_q)
      ST_IDLE: if (tick_i && !rxd_i) begin
        state_n = ST_START;
        cnt_n   = '0;
      end
      ST_START: if (tick_i) begin
        if (cnt_q == MID) begin
          cnt_n = '0;
          if (!rxd_i) begin
            state_n = ST_DATA;
            bidx_n  = '0;
            shr_n   = '0;
            par_n   = 1'b0;
            zero_n  = 1'b1;
          end else begin
            state_n = ST_IDLE;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_DATA: if (tick_i) begin
        cnt_n = cnt_q + 1'b1;
        if (samp) begin
          shr_n  = {rxd_i, shr_q[MAX_BITS-1:1]};
          par_n  = par_q ^ rxd_i;
          zero_n = zero_q && !rxd_i;
          bidx_n = bidx_q + 1'b1;
          if (bidx_q == last_bit) state_n = par_en_i ? ST_PAR : ST_STOP;
        end
      end
      ST_PAR: if (tick_i) begin
        cnt_n = cnt_q + 1'b1;
        if (samp) begin
          par_n   = par_q ^ rxd_i;
          zero_n  = zero_q && !rxd_i;
          state_n = ST_STOP;
        end
      end
      ST_STOP: if (tick_i) begin
        cnt_n = cnt_q + 1'b1;
        if (samp) begin
          done_o       = 1'b1;
          err_o.brk    = brk;
          err_o.frame  = !rxd_i && !brk;
          err_o.parity = par_en_i && !brk && (par_q ^ !par_even_i);
          state_n      = brk ? ST_HOLD : ST_IDLE;
        end
      end
      ST_HOLD: if (rxd_i) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      shr_q   <= '0;
      par_q   <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      bidx_q  <= bidx_n;
      shr_q   <= shr_n;
      par_q   <= par_n;
      zero_q  <= zero_n;
    end
  end

  assign data_o = shr_q >> (SPAN - cfg_len_i);

  // R3: a high line at the mid-start sample abandons the frame
  a_r3_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && tick_i && cnt_q == MID && rxd_i) |=> (state_q == ST_IDLE));

  // R2: the start bit is not left before its middle sample
  a_r2_mid_window: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && !(tick_i && cnt_q == MID)) |=> (state_q == ST_START));

  // R6: no character completes while waiting for the line to rise after a break
  a_r6_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |-> !done_o);
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
  import rxcore_pkg::*;
#(
  parameter int MAX_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  rx_err_t             err_i,
  input  logic                data_rd_i,
  input  logic                stat_rd_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic                ready_o,
  output logic                perr_o,
  output logic                ferr_o,
  output logic                oerr_o,
  output logic                berr_o,
  output logic                irq_o
);
  logic [MAX_BITS-1:0] data_q, data_n;
  logic ready_q, ready_n, perr_q, perr_n, ferr_q, ferr_n;
  logic oerr_q, oerr_n, berr_q, berr_n, irq_q, irq_n;
  logic ovr_set;

  always_comb begin
    ovr_set = done_i && ready_q && !data_rd_i;
    data_n  = done_i ? data_i : data_q;
    ready_n = done_i || (ready_q && !data_rd_i);
    perr_n  = (done_i && err_i.parity) || (perr_q && !stat_rd_i);
    ferr_n  = (done_i && err_i.frame)  || (ferr_q && !stat_rd_i);
    berr_n  = (done_i && err_i.brk)    || (berr_q && !stat_rd_i);
    oerr_n  = ovr_set                  || (oerr_q && !stat_rd_i);
    irq_n   = done_i && (err_i.parity || err_i.frame || err_i.brk || ovr_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      oerr_q  <= 1'b0;
      berr_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      data_q  <= data_n;
      ready_q <= ready_n;
      perr_q  <= perr_n;
      ferr_q  <= ferr_n;
      oerr_q  <= oerr_n;
      berr_q  <= berr_n;
      irq_q   <= irq_n;
    end
  end

  assign data_o  = data_q;
  assign ready_o = ready_q;
  assign perr_o  = perr_q;
  assign ferr_o  = ferr_q;
  assign oerr_o  = oerr_q;
  assign berr_o  = berr_q;
  assign irq_o   = irq_q;

  // R1: a completed character always leaves the ready flag set
  a_r1_load_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> ready_o);

  // R9: a read with no load in the same cycle empties the register
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd_i && !done_i) |=> !ready_o);

  // R7: loading into a full register records an overrun
  a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && ready_o && !data_rd_i) |=> oerr_o);

  // R8: a status read with nothing new arriving clears every flag
  a_r8_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !done_i) |=> !(perr_o || ferr_o || oerr_o || berr_o));

  // R10: the status pulse never appears without a flag raised
  a_r10_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (perr_o || ferr_o || oerr_o || berr_o));
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
  import rxcore_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int MAX_BITS    = 8,
  parameter int MIN_BITS    = 5,
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = $clog2(MAX_BITS - MIN_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick16_i,
  input  logic                rxd_i,
  input  logic [LEN_W-1:0]    cfg_len_i,
  input  logic                cfg_par_en_i,
  input  logic                cfg_par_even_i,
  input  logic                data_rd_i,
  input  logic                stat_rd_i,
  output logic [MAX_BITS-1:0] rx_data_o,
  output logic                rx_ready_o,
  output logic                err_parity_o,
  output logic                err_frame_o,
  output logic                err_overrun_o,
  output logic                err_break_o,
  output logic                rx_irq_o
);
  logic                rxd_s;
  logic                done;
  logic [MAX_BITS-1:0] chr;
  rx_err_t             err;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rxd_i), .q_o(rxd_s)
  );

  rx_frame_ctrl #(
    .OSR(OSR), .MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .tick_i(tick16_i), .rxd_i(rxd_s),
    .cfg_len_i(cfg_len_i), .par_en_i(cfg_par_en_i), .par_even_i(cfg_par_even_i),
    .done_o(done), .data_o(chr), .err_o(err)
  );

  rx_status_regs #(.MAX_BITS(MAX_BITS)) u_stat (
    .clk(clk), .rst_n(rst_n), .done_i(done), .data_i(chr), .err_i(err),
    .data_rd_i(data_rd_i), .stat_rd_i(stat_rd_i),
    .data_o(rx_data_o), .ready_o(rx_ready_o),
    .perr_o(err_parity_o), .ferr_o(err_frame_o), .oerr_o(err_overrun_o),
    .berr_o(err_break_o), .irq_o(rx_irq_o)
  );
endmodule

// File: tb/tb_serial_rx_engine.sv
module tb_serial_rx_engine;
  localparam int BITCLK = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic par_en = 1'b0, par_even = 1'b0;
  logic data_rd = 1'b0, stat_rd = 1'b0;
  logic [1:0] tdiv;
  logic tick;
  logic [7:0] rdata;
  logic rdy, perr, ferr, oerr, berr, irq;
  int checks = 0, fails = 0, pulses = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tdiv <= '0; else tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);

  always @(negedge clk) if (irq) pulses++;

  serial_rx_engine dut (
    .clk(clk), .rst_n(rst_n), .tick16_i(tick), .rxd_i(rxd),
    .cfg_len_i(cfg_len), .cfg_par_en_i(par_en), .cfg_par_even_i(par_even),
    .data_rd_i(data_rd), .stat_rd_i(stat_rd),
    .rx_data_o(rdata), .rx_ready_o(rdy), .err_parity_o(perr),
    .err_frame_o(ferr), .err_overrun_o(oerr), .err_break_o(berr), .rx_irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_len(input logic [7:0] d, input logic [1:0] len);
    return d & ((8'd1 << (5 + len)) - 8'd1);
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic even);
    return even ? ^d : ~^d;
  endfunction

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic pflip, input logic stopv);
    logic [7:0] m;
    m = mask_len(d, cfg_len);
    drive_bit(1'b0);
    for (int i = 0; i < 5 + int'(cfg_len); i++) drive_bit(m[i]);
    if (par_en) drive_bit(par_bit(m, par_even) ^ pflip);
    drive_bit(stopv);
  endtask

  task automatic pulse_rd(input bit dat, input bit st);
    @(negedge clk);
    data_rd = dat; stat_rd = st;
    @(negedge clk);
    data_rd = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic check_flags(input string req, input logic [3:0] exp);
    check({perr, ferr, oerr, berr} == exp, req, {perr, ferr, oerr, berr}, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int p0;
    logic [7:0] d, m;
    logic flip, fr;
    void'($urandom(32'd24681));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    check(rdata == 8'h00 && !rdy, "R11 data/ready", {rdy, rdata}, 0);
    check_flags("R11 flags", 4'b0000);
    check(!irq, "R11 irq", irq, 0);

    // R1: 8-bit, no parity
    cfg_len = 2'd3; par_en = 0;
    p0 = pulses;
    send(8'hA5, 0, 1);
    check(rdy && rdata == 8'hA5, "R1 8-bit data", rdata, 8'hA5);
    check(pulses == p0, "R10 no pulse clean", pulses - p0, 0);
    pulse_rd(1, 1);
    check(!rdy, "R9 ready cleared by read", rdy, 0);

    // R3: false start glitch of 4 ticks
    p0 = pulses;
    rxd = 0; repeat (16) @(negedge clk);
    rxd = 1; repeat (3 * BITCLK) @(negedge clk);
    check(!rdy, "R3 no character after glitch", rdy, 0);
    check(pulses == p0 && {perr, ferr, oerr, berr} == 0, "R3 no flags", {perr, ferr, oerr, berr}, 0);
    send(8'h3C, 0, 1);
    check(rdy && rdata == 8'h3C, "R3 recovers after glitch", rdata, 8'h3C);
    pulse_rd(1, 1);

    // R4: parity errors both modes
    cfg_len = 2'd2; par_en = 1; par_even = 1;
    p0 = pulses;
    send(8'h55, 1, 1);
    check(rdata == 8'h55, "R4 data with even parity", rdata, 8'h55);
    check_flags("R4 even parity error", 4'b1000);
    check(pulses == p0 + 1, "R10 pulse on parity error", pulses - p0, 1);
    pulse_rd(1, 1);
    check_flags("R8 flags cleared", 4'b0000);
    par_even = 0;
    send(8'h12, 1, 1);
    check_flags("R4 odd parity error", 4'b1000);
    pulse_rd(1, 1);
    send(8'h12, 0, 1);
    check_flags("R4 odd parity good", 4'b0000);
    pulse_rd(1, 1);

    // R5: framing error, then sticky until status read
    cfg_len = 2'd0; par_en = 0;
    p0 = pulses;
    send(8'h11, 0, 0);
    rxd = 1; repeat (2 * BITCLK) @(negedge clk);
    check(rdata == 8'h11, "R5 data with framing error", rdata, 8'h11);
    check_flags("R5 framing error", 4'b0100);
    check(pulses == p0 + 1, "R10 pulse on framing", pulses - p0, 1);
    pulse_rd(1, 0);
    check_flags("R8 still sticky after data read", 4'b0100);
    pulse_rd(0, 1);
    check_flags("R8 cleared by status read", 4'b0000);

    // R5/R7: back-to-back with one stop bit, no read between
    cfg_len = 2'd1;
    send(8'h2A, 0, 1);
    send(8'h15, 0, 1);
    check(rdata == 8'h15 && rdy, "R7 new character overwrites", rdata, 8'h15);
    check_flags("R7 overrun only, R5 no framing", 4'b0010);
    pulse_rd(1, 1);

    // R6: break, single zero load, wait for line high
    cfg_len = 2'd3; par_en = 1; par_even = 0;
    p0 = pulses;
    rxd = 0; repeat (13 * BITCLK) @(negedge clk);
    check(rdy && rdata == 8'h00, "R6 zero character on break", rdata, 0);
    check_flags("R6 break flag only", 4'b0001);
    check(pulses == p0 + 1, "R10 single pulse on break", pulses - p0, 1);
    pulse_rd(1, 1);
    repeat (15 * BITCLK) @(negedge clk);
    check(!rdy && {perr, ferr, oerr, berr} == 0, "R6 no reload while low", {rdy, perr, ferr, oerr, berr}, 0);
    rxd = 1; repeat (2 * BITCLK) @(negedge clk);
    send(8'hC3, 0, 1);
    check(rdy && rdata == 8'hC3, "R6 receives after line rises", rdata, 8'hC3);
    pulse_rd(1, 1);

    // R1/R4/R5: random frames
    for (int n = 0; n < 40; n++) begin
      cfg_len = 2'($urandom_range(0, 3));
      par_en = 1'($urandom_range(0, 1));
      par_even = 1'($urandom_range(0, 1));
      d = 8'($urandom);
      flip = par_en && ($urandom_range(0, 4) == 0);
      fr = ($urandom_range(0, 5) == 0);
      if (fr) d[0] = 1'b1;
      m = mask_len(d, cfg_len);
      p0 = pulses;
      send(d, flip, !fr);
      if (fr) begin rxd = 1; repeat (2 * BITCLK) @(negedge clk); end
      check(rdy && rdata == m, "R1 random data", rdata, m);
      check_flags("R4 R5 random flags", {flip, fr, 2'b00});
      check(pulses == p0 + int'(flip || fr), "R10 random pulse", pulses - p0, int'(flip || fr));
      pulse_rd(1, 1);
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule